// File: doc/BRIEF.md
# Cluster Power-Down and Reset-Vector Controller

This block holds the control registers for a cluster of processor cores. Each core has a 64-bit boot address, split into a low word and a high word, and the block drives it out on a per-core vector bus. A power register has one power-down request bit per core. The block takes the wait-for-interrupt status of each core as an asynchronous input. For the power management unit it produces two outputs per core: a power-status bit that mirrors the request, and a ready bit that is set only when the core is both asked to power down and idle in wait-for-interrupt.

Software reaches the registers through a simple 32-bit write port with byte enables and a combinational read port. Only full-word writes take effect. Two plain configuration words with fixed reset values are also held here and driven out.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: Synchronous active-low reset gives these values. Every core vector is 0x00000000_FFFF0000 (low word 0xFFFF0000, high word 0). The first configuration word (offset 0x20) is 0xF0F and the second (offset 0x24) is 0xF000F. All power requests, power-status bits and ready bits are 0.
- R2: A full write to offset 0x40+8*n (low word) or 0x44+8*n (high word) changes core n's vector output to {high, low} from the following cycle. The vectors of other cores keep their values.
- R3: Offset 0x90 holds the power-down requests in bits [NCORE-1:0]. Bit n is core n's request, and the upper bits read back as 0. Each power-status output equals its request bit after the write, and it changes only on a write to 0x90.
- R4: Ready output n equals request n AND the synchronized wait-for-interrupt input n. A change on the input appears at the ready output after exactly two rising clock edges. A change of the request appears at the ready output one edge after the write.
- R5: A write whose byte enables are not all ones (4'hF) has no effect on any register or output.
- R6: Offset 0x94 is a status word. Its read-only bits are those set in 0x3000F. Bits [NCORE-1:0] read back the synchronized wait-for-interrupt inputs, bits 17:16 read 0, and all other bits are stored from full writes.
- R7: The configuration words at 0x20 and 0x24 can be written and read back, and they are driven on cfg_a_o and cfg_b_o. A read of an unmapped offset returns 0.
- R8: Reset clears the requests and the synchronizer state, even when wait-for-interrupt inputs are held high. The ready and power-status outputs are 0 in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables; only 4'hF writes |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| wfi_i | input | NCORE | Asynchronous wait-for-interrupt status per core |
| rvbar_o | output | NCORE*64 | Core vectors; core n in bits [64n+63:64n] |
| pwr_stat_o | output | NCORE | Power-status bit per core |
| pd_ready_o | output | NCORE | Power-down ready bit per core |
| cfg_a_o | output | 32 | First configuration word |
| cfg_b_o | output | 32 | Second configuration word |

## Verification
A wrong request register shows on pwr_stat_o and pd_ready_o in the cycle after the faulty write, and again on a read of 0x90. A stuck or skipped synchronizer stage shifts the ready edge from the second clock edge to the first or the third. The bench samples both cycles after every input change, so this shift is caught. A wrong vector decode puts the write on a neighbouring core's bus one cycle after the write, and the bench checks every affected core as well as an untouched one.

// File: rtl/cpc_pkg.sv
// Package: shared offsets, widths and reset constants for the cluster
// power controller. Assumes a byte-addressed 32-bit register window.
package cpc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFS_CFG_A = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CFG_B = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_VEC   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PWR   = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h94;

    localparam logic [DATA_W-1:0] RST_VEC_LO = 32'hFFFF_0000;
    localparam logic [DATA_W-1:0] RST_VEC_HI = 32'h0000_0000;
    localparam logic [DATA_W-1:0] RST_CFG_A  = 32'h0000_0F0F;
    localparam logic [DATA_W-1:0] RST_CFG_B  = 32'h000F_000F;
    localparam logic [DATA_W-1:0] STAT_RO    = 32'h0003_000F;
endpackage

// File: rtl/cpc_sync.sv
// Module: cpc_sync
// Two-flop synchronizer for a bus of independent asynchronous level bits.
// Assumes each bit is quasi-static, so no multi-bit coherency is needed.
module cpc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two stages of capture into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

    // R8
    sync_clear_chk: assert property (@(posedge clk) !rst_n |=> (sync_q == '0));
endmodule

// File: rtl/cpc_regfile.sv
// Module: cpc_regfile
// Register file: per-core vector pairs, power requests with change-gated
// status bits, a partly read-only status word and two configuration words.
// Assumes only full-word (all byte enables set) writes are legal.
module cpc_regfile
    import cpc_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [BE_W-1:0]        be_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NCORE-1:0]       wfi_sync_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [NCORE-1:0][63:0] vec_o,
    output logic [NCORE-1:0]       req_o,
    output logic [NCORE-1:0]       stat_o,
    output logic [DATA_W-1:0]      cfg_a_o,
    output logic [DATA_W-1:0]      cfg_b_o
);
    localparam int VEC_SPAN = 8;

    logic                          full_wr;
    logic [NCORE-1:0]              lo_hit, hi_hit;
    logic [NCORE-1:0][DATA_W-1:0]  lo_q, hi_q, lo_nx, hi_nx;
    logic [NCORE-1:0][63:0]        vec_q;
    logic [NCORE-1:0]              req_q, stat_q;
    logic [DATA_W-1:0]             word_q, cfg_a_q, cfg_b_q;
    logic                          any_vec_wr;

    assign full_wr = wr_i && (be_i == {BE_W{1'b1}});

    // Per-core decode, next-value and storage of the vector word pairs.
    for (genvar n = 0; n < NCORE; n++) begin : g_vec
        assign lo_hit[n] = full_wr && (addr_i == OFS_VEC + ADDR_W'(VEC_SPAN * n));
        assign hi_hit[n] = full_wr && (addr_i == OFS_VEC + ADDR_W'(VEC_SPAN * n + 4));
        assign lo_nx[n]  = lo_hit[n] ? wdata_i : lo_q[n];
        assign hi_nx[n]  = hi_hit[n] ? wdata_i : hi_q[n];

        // Hold the low and high words of core n.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[n] <= RST_VEC_LO;
                hi_q[n] <= RST_VEC_HI;
            end else begin
                lo_q[n] <= lo_nx[n];
                hi_q[n] <= hi_nx[n];
            end
        end
    end

    assign any_vec_wr = |(lo_hit | hi_hit);

    // Refresh every core's vector output on any vector-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCORE; n++) vec_q[n] <= {RST_VEC_HI, RST_VEC_LO};
        end else if (any_vec_wr) begin
            for (int n = 0; n < NCORE; n++) vec_q[n] <= {hi_nx[n], lo_nx[n]};
        end
    end

    // Power-down request bits, written as a whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)                              req_q <= '0;
        else if (full_wr && addr_i == OFS_PWR)   req_q <= wdata_i[NCORE-1:0];
    end

    // Status bits move only when a write actually flips the request.
    for (genvar n = 0; n < NCORE; n++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[n] <= 1'b0;
            else if (full_wr && addr_i == OFS_PWR && wdata_i[n] != req_q[n])
                stat_q[n] <= wdata_i[n];
        end
    end

    // Writable part of the status word and the two configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            cfg_a_q <= RST_CFG_A;
            cfg_b_q <= RST_CFG_B;
        end else if (full_wr) begin
            if (addr_i == OFS_STAT)  word_q  <= wdata_i & ~STAT_RO;
            if (addr_i == OFS_CFG_A) cfg_a_q <= wdata_i;
            if (addr_i == OFS_CFG_B) cfg_b_q <= wdata_i;
        end
    end

    // Combinational read multiplexer over the register window.
    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_CFG_A)      rdata_o = cfg_a_q;
        else if (addr_i == OFS_CFG_B) rdata_o = cfg_b_q;
        else if (addr_i == OFS_PWR)   rdata_o = DATA_W'(req_q);
        else if (addr_i == OFS_STAT)  rdata_o = (word_q & ~STAT_RO) | DATA_W'(wfi_sync_i);
        else begin
            for (int n = 0; n < NCORE; n++) begin
                if (addr_i == OFS_VEC + ADDR_W'(VEC_SPAN * n))     rdata_o = lo_q[n];
                if (addr_i == OFS_VEC + ADDR_W'(VEC_SPAN * n + 4)) rdata_o = hi_q[n];
            end
        end
    end

    assign vec_o   = vec_q;
    assign req_o   = req_q;
    assign stat_o  = stat_q;
    assign cfg_a_o = cfg_a_q;
    assign cfg_b_o = cfg_b_q;

    // R3
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == OFS_PWR) |=> $stable(stat_o));

    // R5
    partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && be_i != {BE_W{1'b1}}) |=>
            ($stable(vec_o) && $stable(req_o) && $stable(cfg_a_o) && $stable(cfg_b_o)));

    // R2
    vec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && be_i == {BE_W{1'b1}} && addr_i == OFS_VEC) |=>
            (vec_o[0][31:0] == $past(wdata_i)));
endmodule

// File: rtl/cpc_ready.sv
// Module: cpc_ready
// Combines each core's power-down request with its synchronized
// wait-for-interrupt level into the ready bit for the power manager.
// Assumes both inputs are already in the clock domain.
module cpc_ready #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCORE-1:0] req_i,
    input  logic [NCORE-1:0] wfi_i,
    output logic [NCORE-1:0] rdy_o
);
    // One AND gate per core.
    for (genvar n = 0; n < NCORE; n++) begin : g_rdy
        assign rdy_o[n] = req_i[n] & wfi_i[n];

        // R4
        rdy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_o[n] |-> req_i[n]);
    end
endmodule

// File: rtl/cluster_pwr_ctrl.sv
// Module: cluster_pwr_ctrl (top)
// Power-down and boot-vector control for a cluster of NCORE cores.
// Assumes wfi_i is asynchronous and register writes are full words.
module cluster_pwr_ctrl
    import cpc_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [3:0]            reg_be,
    input  logic [7:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NCORE-1:0]      wfi_i,
    output logic [NCORE*64-1:0]   rvbar_o,
    output logic [NCORE-1:0]      pwr_stat_o,
    output logic [NCORE-1:0]      pd_ready_o,
    output logic [31:0]           cfg_a_o,
    output logic [31:0]           cfg_b_o
);
    logic [NCORE-1:0]       wfi_sync;
    logic [NCORE-1:0]       req;
    logic [NCORE-1:0][63:0] vec;

    cpc_sync #(.W(NCORE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wfi_i),
        .sync_o  (wfi_sync)
    );

    cpc_regfile #(.NCORE(NCORE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .be_i       (reg_be),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .wfi_sync_i (wfi_sync),
        .rdata_o    (reg_rdata),
        .vec_o      (vec),
        .req_o      (req),
        .stat_o     (pwr_stat_o),
        .cfg_a_o    (cfg_a_o),
        .cfg_b_o    (cfg_b_o)
    );

    cpc_ready #(.NCORE(NCORE)) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .wfi_i (wfi_sync),
        .rdy_o (pd_ready_o)
    );

    assign rvbar_o = vec;

    // R3
    stat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pwr_stat_o == req));
endmodule

// File: tb/cluster_pwr_ctrl_tb.sv
module cluster_pwr_ctrl_tb;
    localparam int NCORE = 4;
    localparam int S_RD = 0, S_VEC = 1, S_STAT = 2, S_RDY = 3, S_CFGA = 4, S_CFGB = 5;

    typedef struct {
        string       tag;
        int          sel;
        int          idx;
        logic [63:0] exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [3:0] reg_be = 4'hF;
    logic [7:0] reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [NCORE-1:0] wfi_i = '1;
    logic [NCORE*64-1:0] rvbar_o;
    logic [NCORE-1:0] pwr_stat_o, pd_ready_o;
    logic [31:0] cfg_a_o, cfg_b_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sbq[$];

    always #5 clk = ~clk;

    cluster_pwr_ctrl #(.NCORE(NCORE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wfi_i(wfi_i), .rvbar_o(rvbar_o), .pwr_stat_o(pwr_stat_o),
        .pd_ready_o(pd_ready_o), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o)
    );

    task automatic expect_val(input string tag, input int sel, input int idx,
                              input logic [63:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.idx = idx; it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sbq.pop_front();
                case (it.sel)
                    S_RD:    act = {32'h0, reg_rdata};
                    S_VEC:   act = rvbar_o[it.idx*64 +: 64];
                    S_STAT:  act = {60'h0, pwr_stat_o};
                    S_RDY:   act = {60'h0, pd_ready_o};
                    S_CFGA:  act = {32'h0, cfg_a_o};
                    default: act = {32'h0, cfg_b_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_addr = 8'h40;
        // R1 reset state
        for (int n = 0; n < NCORE; n++) expect_val("R1 vector", S_VEC, n, 64'h0000_0000_FFFF_0000);
        expect_val("R1 cfg_a", S_CFGA, 0, 64'hF0F);
        expect_val("R1 cfg_b", S_CFGB, 0, 64'hF000F);
        expect_val("R1 pwr_stat", S_STAT, 0, 64'h0);
        expect_val("R1 ready", S_RDY, 0, 64'h0);
        expect_val("R1 low read", S_RD, 0, 64'hFFFF_0000);

        // R2 vector writes to core 1, core 0 untouched
        wr32(8'h4C, 32'h1234_5678, 4'hF);
        expect_val("R2 core1 hi", S_VEC, 1, 64'h1234_5678_FFFF_0000);
        expect_val("R2 core0 kept", S_VEC, 0, 64'h0000_0000_FFFF_0000);
        wr32(8'h48, 32'h0000_8000, 4'hF);
        expect_val("R2 core1 lo", S_VEC, 1, 64'h1234_5678_0000_8000);
        wr32(8'h58, 32'hAAAA_0000, 4'hF);
        expect_val("R2 core3 lo", S_VEC, 3, 64'h0000_0000_AAAA_0000);
        expect_val("R2 core2 kept", S_VEC, 2, 64'h0000_0000_FFFF_0000);

        // R5 partial writes ignored
        wr32(8'h40, 32'h0000_DEAD, 4'h3);
        expect_val("R5 vector", S_VEC, 0, 64'h0000_0000_FFFF_0000);
        wr32(8'h90, 32'hF, 4'h7);
        expect_val("R5 pwr", S_STAT, 0, 64'h0);

        // R3 requests (wfi synced high since reset release)
        wr32(8'h90, 32'hFFFF_FFF5, 4'hF);
        expect_val("R3 pwr_stat", S_STAT, 0, 64'h5);
        expect_val("R3 readback", S_RD, 0, 64'h5);
        expect_val("R4 ready req", S_RDY, 0, 64'h5);

        // R4 two-edge latency of wfi
        @(negedge clk);
        wfi_i = 4'h0;
        @(negedge clk);
        expect_val("R4 ready one edge", S_RDY, 0, 64'h5);
        @(negedge clk);
        expect_val("R4 ready two edges", S_RDY, 0, 64'h0);
        wfi_i = 4'hA;
        repeat (2) @(negedge clk);
        expect_val("R4 ready disjoint", S_RDY, 0, 64'h0);
        wr32(8'h90, 32'hA, 4'hF);
        expect_val("R4 ready after req", S_RDY, 0, 64'hA);
        expect_val("R3 pwr_stat 2", S_STAT, 0, 64'hA);

        // R6 status word
        wr32(8'h94, 32'hFFFF_FFFF, 4'hF);
        expect_val("R6 status read", S_RD, 0, 64'hFFFC_FFFA);

        // R7 configuration and unmapped read
        wr32(8'h20, 32'h0000_0001, 4'hF);
        expect_val("R7 cfg_a", S_CFGA, 0, 64'h1);
        expect_val("R7 cfg_a read", S_RD, 0, 64'h1);
        wr32(8'h24, 32'h0000_0042, 4'hF);
        expect_val("R7 cfg_b", S_CFGB, 0, 64'h42);
        @(negedge clk);
        reg_addr = 8'h88;
        expect_val("R7 unmapped", S_RD, 0, 64'h0);

        // R8 reset with wfi held high
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        expect_val("R8 pwr_stat", S_STAT, 0, 64'h0);
        expect_val("R8 ready", S_RDY, 0, 64'h0);
        expect_val("R8 vector", S_VEC, 1, 64'h0000_0000_FFFF_0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule